// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

This block merges the event flags of nine audio DMA channels into a single interrupt line. Each channel reports three kinds of event: a finished period, an underrun and an error. Each kind is latched into a sticky pending bit. Software programs an enable word that selects which pending bits may reach the interrupt line. It can read the pending bits both with and without that mask. It acknowledges events by writing ones to a clear location. It can also inject events through a force location, to test the interrupt path.

A typical handler reads the masked view and writes that same word to the clear location. This acknowledges every event it saw in one access. The downstream interrupt controller samples the line on its rising edge. For that reason the line must drop once all enabled events are cleared, and it must rise again when a new event arrives.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, the enable, masked and raw views all read zero, and irq_o is low.
- R2: A one-cycle pulse on evt_i[b] sets raw bit b on the next clock edge, and the bit stays set until it is cleared. Channel n owns bits 3n..3n+2: bit 3n is period done, bit 3n+1 is underrun and bit 3n+2 is error.
- R3: The register at byte offset 0x00 is the enable word and reads back as written. The word at offset 0x04 reads as raw AND enable.
- R4: irq_o is high exactly when at least one bit of the masked view is set.
- R5: Writing to offset 0x0C clears every raw bit written as one. Bits written as zero keep their state.
- R6: An event in the same cycle as a clear of its bit leaves the bit set.
- R7: Writing ones to offset 0x10 sets the matching raw bits on the next edge, just as events on evt_i would. Offsets 0x0C and 0x10 read as zero.
- R8: Clearing an enable bit removes that bit from the masked view and from irq_o, and leaves the raw bit unchanged.
- R9: Bits 31..27 of every register read as zero. Writes to those bits have no effect.
- R10: After a clear drops irq_o, a new enabled event raises irq_o again.
- R11: Writes to the masked-view offset 0x04 and the raw-view offset 0x08 do not change any state.
- R12: Writing the masked view back to the clear offset clears only the reported bits. Pending bits that are disabled survive and stay visible in the raw view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 27 | Event pulses, three per channel |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write qualifier for req_i |
| addr_i | input | 5 | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Aggregated interrupt, high while any enabled bit is pending |

## Verification
The bench drives an event and a clear of the same bit in the same cycle. A design that gave the clear priority would lose that event and would never interrupt for it. The bench also lets irq_o fall after a clear and then sends a new event. A design that held or latched the line would produce no second rising edge, and the consumer would miss the event. The bench disables bits that are pending and then writes the masked view back to the clear offset. A design that cleared or masked the raw state would lose events that are hidden but still pending. The bench writes the reserved bits and the read-only offsets, which catches a design that decodes addresses loosely or stores data it should ignore.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;
  localparam int unsigned NUM_CH     = 9;
  localparam int unsigned EVT_PER_CH = 3;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 5;

  // word index = byte offset / 4
  typedef enum logic [2:0] {
    REG_ENABLE = 3'd0,
    REG_MASKED = 3'd1,
    REG_RAW    = 3'd2,
    REG_CLEAR  = 3'd3,
    REG_FORCE  = 3'd4
  } reg_sel_e;

  // position of each event kind inside a channel group
  localparam int unsigned EVT_PERIOD = 0;
  localparam int unsigned EVT_UNDER  = 1;
  localparam int unsigned EVT_ERROR  = 2;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import dma_irq_agg_pkg::*;
#(
  parameter int unsigned EVT_W  = 27,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [EVT_W-1:0]  en_q_i,
  input  logic [EVT_W-1:0]  raw_q_i,
  output logic              en_we_o,
  output logic [EVT_W-1:0]  en_wdata_o,
  output logic [EVT_W-1:0]  clr_mask_o,
  output logic [EVT_W-1:0]  set_mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned PAD_W = DATA_W - EVT_W;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr;
  logic [EVT_W-1:0] wbits;
  logic [EVT_W-1:0] view;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign wbits   = wdata_i[EVT_W-1:0]; // reserved bits dropped here

  assign en_we_o    = wr & (idx == IDX_W'(REG_ENABLE));
  assign en_wdata_o = wbits;
  assign clr_mask_o = (wr && idx == IDX_W'(REG_CLEAR)) ? wbits : '0;
  assign set_mask_o = (wr && idx == IDX_W'(REG_FORCE)) ? wbits : '0;

  always_comb begin
    view = '0;
    if (aligned) begin
      if (idx == IDX_W'(REG_ENABLE))      view = en_q_i;
      else if (idx == IDX_W'(REG_MASKED)) view = raw_q_i & en_q_i;
      else if (idx == IDX_W'(REG_RAW))    view = raw_q_i;
    end
  end

  assign rdata_o = {{PAD_W{1'b0}}, view};
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int unsigned NUM_CH     = 9,
  parameter int unsigned EVT_PER_CH = 3,
  parameter int unsigned EVT_W      = NUM_CH * EVT_PER_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [EVT_W-1:0] en_wdata_i,
  output logic [EVT_W-1:0] raw_o,
  output logic [EVT_W-1:0] en_o,
  output logic [NUM_CH-1:0] ch_pend_o
);
  logic [EVT_W-1:0] raw_q;
  logic [EVT_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int unsigned BASE = ch * EVT_PER_CH;
    for (genvar k = 0; k < EVT_PER_CH; k++) begin : g_bit
      // set beats clear so a colliding event is never lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 raw_q[BASE+k] <= 1'b0;
        else if (evt_i[BASE+k] || set_i[BASE+k])     raw_q[BASE+k] <= 1'b1;
        else if (clr_i[BASE+k])                      raw_q[BASE+k] <= 1'b0;
      end
    end
    assign ch_pend_o[ch] = |(raw_q[BASE +: EVT_PER_CH] & en_q[BASE +: EVT_PER_CH]);
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_agg_pkg::*;
#(
  parameter int unsigned N_CH    = dma_irq_agg_pkg::NUM_CH,
  parameter int unsigned N_EVT   = dma_irq_agg_pkg::EVT_PER_CH,
  parameter int unsigned DW      = dma_irq_agg_pkg::DATA_W,
  parameter int unsigned AW      = dma_irq_agg_pkg::ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH*N_EVT-1:0]  evt_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   irq_o
);
  localparam int unsigned EVT_W = N_CH * N_EVT;

  logic             en_we;
  logic [EVT_W-1:0] en_wdata;
  logic [EVT_W-1:0] clr_mask;
  logic [EVT_W-1:0] set_mask;
  logic [EVT_W-1:0] raw_q;
  logic [EVT_W-1:0] en_q;
  logic [N_CH-1:0]  ch_pend;

  irq_reg_decode #(
    .EVT_W (EVT_W),
    .DATA_W(DW),
    .ADDR_W(AW)
  ) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .en_q_i    (en_q),
    .raw_q_i   (raw_q),
    .en_we_o   (en_we),
    .en_wdata_o(en_wdata),
    .clr_mask_o(clr_mask),
    .set_mask_o(set_mask),
    .rdata_o   (rdata_o)
  );

  irq_event_bank #(
    .NUM_CH    (N_CH),
    .EVT_PER_CH(N_EVT),
    .EVT_W     (EVT_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .set_i     (set_mask),
    .clr_i     (clr_mask),
    .en_we_i   (en_we),
    .en_wdata_i(en_wdata),
    .raw_o     (raw_q),
    .en_o      (en_q),
    .ch_pend_o (ch_pend)
  );

  assign irq_o = |ch_pend;
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int unsigned EVT_W  = 27,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [EVT_W-1:0]  evt_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [EVT_W-1:0]  raw_q,
  input logic [EVT_W-1:0]  en_q,
  input logic [EVT_W-1:0]  clr_mask,
  input logic [EVT_W-1:0]  set_mask
);
  // R2 R6 R7: every event or forced bit is pending one edge later
  p_evt_sets_raw_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(evt_i | set_mask)) == $past(evt_i | set_mask)));

  // R5: bits not being cleared stay set
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr_mask)) == $past(raw_q & ~clr_mask)));

  // R5: a clear with no colliding set empties the bit
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(clr_mask & ~(evt_i | set_mask))) == '0));

  // R4: no enable, no interrupt
  p_irq_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  // R4: interrupt needs a pending raw bit
  p_irq_needs_raw_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_q != '0));

  // R9: reserved bits never read as one
  p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:EVT_W] == '0);
endmodule

bind dma_irq_agg dma_irq_agg_chk #(
  .EVT_W (EVT_W),
  .DATA_W(DW)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .irq_o   (irq_o),
  .rdata_o (rdata_o),
  .raw_q   (raw_q),
  .en_q    (en_q),
  .clr_mask(clr_mask),
  .set_mask(set_mask)
);

// File: tb/dma_irq_agg_tb_top.sv
`timescale 1ns/1ps
module dma_irq_agg_tb_top;
  localparam logic [4:0]  A_EN  = 5'h00;
  localparam logic [4:0]  A_MSK = 5'h04;
  localparam logic [4:0]  A_RAW = 5'h08;
  localparam logic [4:0]  A_CLR = 5'h0C;
  localparam logic [4:0]  A_FRC = 5'h10;
  localparam logic [31:0] ALL   = 32'h07FF_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [26:0] evt_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dma_irq_agg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] bitof(input int ch, input int kind);
    return 32'h1 << (3 * ch + kind);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk_i);
    evt_i = m[26:0];
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic scrub();
    wr(A_EN, 32'h0);
    wr(A_CLR, ALL);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_EN, d);  check("R1 enable", d, 32'h0);
    rd(A_MSK, d); check("R1 masked", d, 32'h0);
    rd(A_RAW, d); check("R1 raw", d, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    scrub();
    pulse(bitof(4, 1)); // ch4 underrun -> bit 13
    repeat (3) @(negedge clk_i);
    rd(A_RAW, d); check("R2 sticky underrun bit13", d, 32'h0000_2000);
    rd(A_MSK, d); check("R3 masked with no enable", d, 32'h0);
    check("R4 irq off when disabled", {31'h0, irq_o}, 32'h0);
    pulse(bitof(0, 0) | bitof(2, 2)); // bits 0 and 8
    rd(A_RAW, d); check("R2 period+error bits", d, 32'h0000_2101);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(A_EN, 32'h0000_2010);
    rd(A_EN, d);  check("R3 enable readback", d, 32'h0000_2010);
    rd(A_MSK, d); check("R3 masked view", d, 32'h0000_2000);
    check("R4 irq on", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_clear_rearm();
    logic [31:0] d;
    wr(A_CLR, 32'h0);
    rd(A_RAW, d); check("R5 zero write keeps", d, 32'h0000_2101);
    wr(A_CLR, 32'h0000_2000);
    rd(A_RAW, d); check("R5 w1c bit13", d, 32'h0000_0101);
    check("R10 irq drops", {31'h0, irq_o}, 32'h0);
    pulse(32'h0000_2000);
    rd(A_MSK, d); check("R10 masked again", d, 32'h0000_2000);
    check("R10 irq rises again", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk_i);
    evt_i = 27'h000_2000;
    req_i = 1'b1; we_i = 1'b1; addr_i = A_CLR; wdata_i = 32'h0000_2101;
    @(negedge clk_i);
    evt_i = '0; req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    rd(A_RAW, d); check("R6 event beats clear", d, 32'h0000_2000);
    check("R6 irq stays", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_force();
    logic [31:0] d;
    scrub();
    wr(A_FRC, bitof(8, 2)); // ch8 error -> bit 26
    rd(A_RAW, d); check("R7 forced bit26", d, 32'h0400_0000);
    rd(A_FRC, d); check("R7 force reads zero", d, 32'h0);
    rd(A_CLR, d); check("R7 clear reads zero", d, 32'h0);
    wr(A_EN, 32'h0400_0000);
    check("R7 forced raises irq", {31'h0, irq_o}, 32'h1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(A_EN, 32'h0);
    rd(A_MSK, d); check("R8 masked hidden", d, 32'h0);
    check("R8 irq hidden", {31'h0, irq_o}, 32'h0);
    rd(A_RAW, d); check("R8 raw kept", d, 32'h0400_0000);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    scrub();
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R9 enable reserved", d, ALL);
    wr(A_FRC, 32'hF800_0000);
    rd(A_RAW, d); check("R9 force reserved ignored", d, 32'h0);
    check("R9 irq after reserved force", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    pulse(bitof(3, 0)); // bit 9
    wr(A_RAW, 32'h0);
    wr(A_MSK, 32'h0);
    rd(A_RAW, d); check("R11 raw write ignored", d, 32'h0000_0200);
    wr(A_RAW, ALL);
    rd(A_RAW, d); check("R11 raw set ignored", d, 32'h0000_0200);
    rd(A_EN, d);  check("R11 enable untouched", d, ALL);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    scrub();
    pulse(32'h0000_0249); // bits 0,3,6,9
    wr(A_EN, 32'h0000_0009); // bits 0,3
    rd(A_MSK, d);
    check("R12 reported set", d, 32'h0000_0009);
    wr(A_CLR, d);
    rd(A_MSK, d); check("R12 masked empty", d, 32'h0);
    rd(A_RAW, d); check("R12 hidden survive", d, 32'h0000_0240);
    check("R12 irq low", {31'h0, irq_o}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_capture();
    t_enable();
    t_clear_rearm();
    t_collide();
    t_force();
    t_disable();
    t_reserved();
    t_readonly();
    t_ack();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule